// File: doc/BRIEF.md
# Add-Class Arithmetic Unit with Carry and Overflow Flags

This block is the combinational core of the fixed-point add path. It accepts two 64-bit operands, a select for the kind of add operation, an overflow-enable bit and the current carry and overflow flag values. From these it forms the 64-bit result and four flags:

- a carry flag and a signed-overflow flag for the full 64-bit width;
- a carry flag and an overflow flag as they would come out of a 32-bit operation on the low word.

It also drives two write strobes. These tell the flag register outside the block which flags this operation is allowed to update.

The supported operations are:

- a plain add;
- an add that records its carry;
- a subtract-from, formed as the inverted first operand plus the second plus one;
- a negate;
- an extended add that chains the stored carry in;
- an extended add that chains the stored overflow flag in and returns its carry-out through the overflow outputs. This lets the overflow flag act as a second, independent carry chain.

The block holds no state. All outputs settle from the inputs within the same cycle.

Top module: `flag_adder`

## Requirements
- R1: Mode code 0 (plain add) gives `sum_o` = `a_i` + `b_i` modulo 2^64, with a carry-in of 0 and `carry_we_o` = 0.
- R2: Mode code 1 (add recording carry) gives `sum_o` = `a_i` + `b_i`. `carry_o` is the carry out of bit 63 and `carry_we_o` = 1.
- R3: Mode code 2 (subtract-from) gives `sum_o` = ~`a_i` + `b_i` + 1, which equals `b_i` − `a_i`. `carry_we_o` = 0.
- R4: Mode code 3 (negate) gives `sum_o` = ~`a_i` + 1, and `b_i` is ignored. `ovf_o` is 1 only when `a_i` is 0x8000_0000_0000_0000.
- R5: Mode code 4 (extended add) gives `sum_o` = `a_i` + `b_i` + `carry_flag_i`. `carry_o` is the carry out of bit 63 and `carry_we_o` = 1.
- R6: Mode code 5 (extended add through overflow) behaves as follows:
  - `sum_o` = `a_i` + `b_i` + `ovf_flag_i`;
  - `ovf_o` is the carry out of bit 63 and `ovf32_o` is the carry out of bit 31;
  - `carry_we_o` = 0 and `ovf_we_o` = 1, whatever the value of `oe_i`.
- R7: In modes 0 to 4, `ovf_o` is 1 exactly when the carry out of bit 63 differs from the carry into bit 63.
- R8: In modes 0 to 4, `ovf32_o` is 1 exactly when the carry out of bit 31 differs from the carry into bit 31.
- R9: In every mode, `carry32_o` is the carry out of bit 31 of the sum and `carry_o` is the carry out of bit 63.
- R10: In modes 0 to 4, `ovf_we_o` equals `oe_i`.
- R11: Mode codes 6 and 7 are reserved. They drive `carry_we_o` = 0 and `ovf_we_o` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 64 | First operand (inverted in subtract-from and negate) |
| b_i | input | 64 | Second operand (unused in negate) |
| carry_flag_i | input | 1 | Stored carry flag, used as carry-in by mode 4 |
| ovf_flag_i | input | 1 | Stored overflow flag, used as carry-in by mode 5 |
| mode_i | input | 3 | Operation select, codes 0 to 5 (6 and 7 reserved) |
| oe_i | input | 1 | Overflow-enable bit for modes 0 to 4 |
| sum_o | output | 64 | Result |
| carry_o | output | 1 | Carry out of bit 63 |
| carry32_o | output | 1 | Carry out of bit 31 |
| ovf_o | output | 1 | 64-bit overflow, or carry-out in mode 5 |
| ovf32_o | output | 1 | 32-bit overflow, or bit-31 carry-out in mode 5 |
| carry_we_o | output | 1 | Strobe: the operation updates both carry flags |
| ovf_we_o | output | 1 | Strobe: the operation updates both overflow flags |

## Verification
The bench builds the block with its default `WIDTH` of 64, so the segment split falls at bit 31. With that width, the carry into and out of bits 31 and 63 are all reachable with chosen operand values. This covers:

- the most negative value under negate;
- all-ones operands chained with each stored flag;
- sign-boundary operands that overflow in one half and not the other.

A model of the requirements written with 65-bit and 33-bit arithmetic then checks a long pseudo-random run across all eight mode codes.

// File: rtl/flag_adder_pkg.sv
// Package: shared mode encoding for the add-class flag unit.
// Assumes a 3-bit operation select; codes 6 and 7 are reserved.
package flag_adder_pkg;

    typedef enum logic [2:0] {
        MODE_ADD         = 3'd0,
        MODE_ADD_CARRY   = 3'd1,
        MODE_SUB_FROM    = 3'd2,
        MODE_NEGATE      = 3'd3,
        MODE_ADD_EXT     = 3'd4,
        MODE_ADD_EXT_OVF = 3'd5,
        MODE_RSVD6       = 3'd6,
        MODE_RSVD7       = 3'd7
    } add_mode_e;

endpackage

// File: rtl/flag_adder_operands.sv
// Module: operand preparation.
// Picks the operand inversion, the second-operand masking and the carry-in
// for each mode. Assumes reserved modes behave as a plain add.
module flag_adder_operands
    import flag_adder_pkg::*;
#(
    parameter int WIDTH = 64
) (
    input  add_mode_e         mode,
    input  logic [WIDTH-1:0]  a,
    input  logic [WIDTH-1:0]  b,
    input  logic              carry_flag,
    input  logic              ovf_flag,
    output logic [WIDTH-1:0]  opa,
    output logic [WIDTH-1:0]  opb,
    output logic              cin
);

    // Select the adder inputs for the requested operation.
    always_comb begin
        opa = a;
        opb = b;
        cin = 1'b0;
        unique case (mode)
            MODE_SUB_FROM: begin
                opa = ~a;
                cin = 1'b1;
            end
            MODE_NEGATE: begin
                opa = ~a;
                opb = '0;
                cin = 1'b1;
            end
            MODE_ADD_EXT:     cin = carry_flag;
            MODE_ADD_EXT_OVF: cin = ovf_flag;
            default: begin
                opa = a;
                opb = b;
                cin = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/flag_adder_segment.sv
// Module: one adder segment of W bits with carry in and carry out.
// Assumes W >= 1; the segment boundaries expose the carries that the flags need.
module flag_adder_segment #(
    parameter int W = 31
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] s,
    output logic         cout
);

    localparam int SW = W + 1;

    logic [SW-1:0] total;

    // Widened add so that the carry out lands in the top bit.
    always_comb begin
        total = {1'b0, x} + {1'b0, y} + SW'(cin);
    end

    assign s    = total[W-1:0];
    assign cout = total[W];

endmodule

// File: rtl/flag_adder_flags.sv
// Module: flag and write-strobe generation.
// Takes the carries into and out of the top bit of each half and forms the
// carry, overflow and strobe outputs. Assumes the carries are already settled.
module flag_adder_flags
    import flag_adder_pkg::*;
(
    input  add_mode_e mode,
    input  logic      oe,
    input  logic      hi_cin,
    input  logic      hi_cout,
    input  logic      lo_cin,
    input  logic      lo_cout,
    output logic      carry,
    output logic      carry32,
    output logic      ovf,
    output logic      ovf32,
    output logic      carry_we,
    output logic      ovf_we
);

    // Carries are reported as is; overflow is either the signed test or the carry.
    always_comb begin
        carry   = hi_cout;
        carry32 = lo_cout;
        if (mode == MODE_ADD_EXT_OVF) begin
            ovf   = hi_cout;
            ovf32 = lo_cout;
        end else begin
            ovf   = hi_cout ^ hi_cin;
            ovf32 = lo_cout ^ lo_cin;
        end
    end

    // Decide which flag groups this operation may update.
    always_comb begin
        carry_we = 1'b0;
        ovf_we   = 1'b0;
        unique case (mode)
            MODE_ADD, MODE_SUB_FROM, MODE_NEGATE: ovf_we = oe;
            MODE_ADD_CARRY, MODE_ADD_EXT: begin
                carry_we = 1'b1;
                ovf_we   = oe;
            end
            MODE_ADD_EXT_OVF: ovf_we = 1'b1;
            default: begin
                carry_we = 1'b0;
                ovf_we   = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/flag_adder.sv
// Module: top of the add-class unit with 64-bit and 32-bit flags.
// Splits the adder into two halves. Each half is a body segment plus a
// single top-bit segment, so the carries into and out of bits HALF-1 and
// WIDTH-1 are visible. Purely combinational; assumes WIDTH is even and >= 4.
module flag_adder
    import flag_adder_pkg::*;
#(
    parameter int WIDTH = 64
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             carry_flag_i,
    input  logic             ovf_flag_i,
    input  logic [2:0]       mode_i,
    input  logic             oe_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             carry_o,
    output logic             carry32_o,
    output logic             ovf_o,
    output logic             ovf32_o,
    output logic             carry_we_o,
    output logic             ovf_we_o
);

    localparam int HALF   = WIDTH / 2;
    localparam int NHALF  = 2;
    localparam int NCARRY = 2 * NHALF + 1;

    add_mode_e        mode;
    logic [WIDTH-1:0] opa;
    logic [WIDTH-1:0] opb;
    logic             cin;
    logic [NCARRY-1:0] chain;

    assign mode = add_mode_e'(mode_i);

    flag_adder_operands #(.WIDTH(WIDTH)) u_ops (
        .mode       (mode),
        .a          (a_i),
        .b          (b_i),
        .carry_flag (carry_flag_i),
        .ovf_flag   (ovf_flag_i),
        .opa        (opa),
        .opb        (opb),
        .cin        (cin)
    );

    assign chain[0] = cin;

    // Each half: a body of HALF-1 bits, then its top bit on its own.
    for (genvar h = 0; h < NHALF; h++) begin : g_half
        localparam int LO  = h * HALF;
        localparam int TOP = LO + HALF - 1;

        flag_adder_segment #(.W(HALF - 1)) u_body (
            .x    (opa[TOP-1:LO]),
            .y    (opb[TOP-1:LO]),
            .cin  (chain[2*h]),
            .s    (sum_o[TOP-1:LO]),
            .cout (chain[2*h+1])
        );

        flag_adder_segment #(.W(1)) u_topbit (
            .x    (opa[TOP:TOP]),
            .y    (opb[TOP:TOP]),
            .cin  (chain[2*h+1]),
            .s    (sum_o[TOP:TOP]),
            .cout (chain[2*h+2])
        );
    end

    flag_adder_flags u_flags (
        .mode     (mode),
        .oe       (oe_i),
        .hi_cin   (chain[3]),
        .hi_cout  (chain[4]),
        .lo_cin   (chain[1]),
        .lo_cout  (chain[2]),
        .carry    (carry_o),
        .carry32  (carry32_o),
        .ovf      (ovf_o),
        .ovf32    (ovf32_o),
        .carry_we (carry_we_o),
        .ovf_we   (ovf_we_o)
    );

endmodule

// File: rtl/flag_adder_chk.sv
// Module: checker for flag_adder, attached by bind.
// Relates the ports at every settled input change; the block has no state.
module flag_adder_chk
    import flag_adder_pkg::*;
#(
    parameter int WIDTH = 64
) (
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic [2:0]       mode_i,
    input logic             oe_i,
    input logic [WIDTH-1:0] sum_o,
    input logic             carry_o,
    input logic             carry32_o,
    input logic             ovf_o,
    input logic             ovf32_o,
    input logic             carry_we_o,
    input logic             ovf_we_o
);

    localparam int HALF = WIDTH / 2;
    localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};

    add_mode_e md;
    assign md = add_mode_e'(mode_i);

    // Check per-mode relations between operands, result and flags.
    always_comb begin
        if (md == MODE_ADD) begin
            // R1
            plain_sum_chk: assert (sum_o == a_i + b_i && !carry_we_o);
            // R7
            signed_ovf_chk: assert (ovf_o == ((a_i[WIDTH-1] == b_i[WIDTH-1]) && (sum_o[WIDTH-1] != a_i[WIDTH-1])));
            // R8
            low_ovf_chk: assert (ovf32_o == ((a_i[HALF-1] == b_i[HALF-1]) && (sum_o[HALF-1] != a_i[HALF-1])));
        end
        if (md == MODE_ADD_CARRY || md == MODE_ADD_EXT) begin
            // R2
            carry_strobe_chk: assert (carry_we_o);
        end
        if (md == MODE_SUB_FROM) begin
            // R3
            sub_from_chk: assert (sum_o == b_i - a_i && !carry_we_o);
        end
        if (md == MODE_NEGATE) begin
            // R4
            neg_ovf_chk: assert (ovf_o == (a_i == MOST_NEG));
        end
        if (md == MODE_ADD_EXT_OVF) begin
            // R6
            ovf_as_carry_chk: assert (ovf_o == carry_o && ovf32_o == carry32_o && !carry_we_o && ovf_we_o);
        end
        if (mode_i < 3'd5) begin
            // R10
            ovf_strobe_chk: assert (ovf_we_o == oe_i);
        end
        if (mode_i > 3'd5) begin
            // R11
            reserved_quiet_chk: assert (!carry_we_o && !ovf_we_o);
        end
    end

endmodule

bind flag_adder flag_adder_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/flag_adder_test.sv
`timescale 1ns/1ps
// Bench: directed scenarios plus a pseudo-random sweep against a model
// built from the requirements with 65-bit and 33-bit arithmetic.
module flag_adder_test;

    localparam int W = 64;
    localparam logic [W-1:0] MOST_NEG = 64'h8000_0000_0000_0000;
    localparam logic [W-1:0] ONES     = '1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_i = '0, b_i = '0;
    logic         carry_flag_i = 1'b0, ovf_flag_i = 1'b0, oe_i = 1'b0;
    logic [2:0]   mode_i = 3'd0;
    logic [W-1:0] sum_o;
    logic         carry_o, carry32_o, ovf_o, ovf32_o, carry_we_o, ovf_we_o;

    int  total = 0;
    int  bad = 0;
    bit  finished = 1'b0;

    always #2.5 clk = ~clk;

    flag_adder uut (
        .a_i(a_i), .b_i(b_i), .carry_flag_i(carry_flag_i), .ovf_flag_i(ovf_flag_i),
        .mode_i(mode_i), .oe_i(oe_i), .sum_o(sum_o), .carry_o(carry_o),
        .carry32_o(carry32_o), .ovf_o(ovf_o), .ovf32_o(ovf32_o),
        .carry_we_o(carry_we_o), .ovf_we_o(ovf_we_o)
    );

    // One compare, counted; prints a FAIL line on mismatch.
    task automatic chk(input string tag, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Drive one operation, let it settle away from the edge, then compare all outputs.
    task automatic run_op(input string tag, input logic [2:0] m, input logic [W-1:0] a, input logic [W-1:0] b,
                          input logic cf, input logic of, input logic oe);
        logic [W-1:0] xa, xb;
        logic         ci;
        logic [W:0]   wide;
        logic [32:0]  low;
        logic         e_ov, e_ov32, e_cwe, e_owe;
        @(negedge clk);
        a_i = a; b_i = b; carry_flag_i = cf; ovf_flag_i = of; oe_i = oe; mode_i = m;
        xa = (m == 3'd2 || m == 3'd3) ? ~a : a;
        xb = (m == 3'd3) ? '0 : b;
        ci = (m == 3'd2 || m == 3'd3) ? 1'b1 : (m == 3'd4) ? cf : (m == 3'd5) ? of : 1'b0;
        wide = {1'b0, xa} + {1'b0, xb} + {{W{1'b0}}, ci};
        low  = {1'b0, xa[31:0]} + {1'b0, xb[31:0]} + {32'd0, ci};
        if (m == 3'd5) begin
            e_ov = wide[W]; e_ov32 = low[32];
        end else begin
            e_ov   = (xa[63] == xb[63]) && (wide[63] != xa[63]);
            e_ov32 = (xa[31] == xb[31]) && (low[31] != xa[31]);
        end
        e_cwe = (m == 3'd1 || m == 3'd4);
        e_owe = (m == 3'd5) ? 1'b1 : (m < 3'd5) ? oe : 1'b0;
        #1;
        chk(tag, "sum", sum_o, wide[W-1:0]);
        chk(tag, "carry", W'(carry_o), W'(wide[W]));
        chk(tag, "carry32", W'(carry32_o), W'(low[32]));
        chk(tag, "ovf", W'(ovf_o), W'(e_ov));
        chk(tag, "ovf32", W'(ovf32_o), W'(e_ov32));
        chk(tag, "carry_we", W'(carry_we_o), W'(e_cwe));
        chk(tag, "ovf_we", W'(ovf_we_o), W'(e_owe));
    endtask

    // Quiet inputs after reset give a zero result and no strobes.
    task automatic t_reset;
        @(negedge clk);
        #1;
        chk("R1 reset", "sum", sum_o, '0);
        chk("R1 reset", "strobes", W'({carry_we_o, ovf_we_o}), '0);
        chk("R7 reset", "ovf", W'(ovf_o), '0);
    endtask

    // Plain add, including sign-boundary overflow in each half.
    task automatic t_add;
        run_op("R1", 3'd0, 64'd5, 64'd7, 1'b1, 1'b1, 1'b0);
        run_op("R7", 3'd0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 1'b0, 1'b0, 1'b1);
        chk("R7", "ovf set", W'(ovf_o), W'(1'b1));
        run_op("R8", 3'd0, 64'h0000_0000_7FFF_FFFF, 64'd1, 1'b0, 1'b0, 1'b1);
        chk("R8", "ovf32 set", W'(ovf32_o), W'(1'b1));
        chk("R8", "ovf clear", W'(ovf_o), W'(1'b0));
        run_op("R10", 3'd0, MOST_NEG, MOST_NEG, 1'b0, 1'b0, 1'b0);
        chk("R10", "ovf_we off", W'(ovf_we_o), W'(1'b0));
    endtask

    // Add recording carry: all-ones plus one carries out of both halves.
    task automatic t_add_carry;
        run_op("R2", 3'd1, ONES, 64'd1, 1'b0, 1'b0, 1'b0);
        chk("R2", "carry set", W'(carry_o), W'(1'b1));
        run_op("R9", 3'd1, 64'h0000_0000_FFFF_FFFF, 64'd1, 1'b0, 1'b0, 1'b1);
        chk("R9", "carry32 only", W'({carry_o, carry32_o}), W'(2'b01));
    endtask

    // Subtract-from: b minus a, both directions.
    task automatic t_subf;
        run_op("R3", 3'd2, 64'd3, 64'd10, 1'b0, 1'b0, 1'b1);
        chk("R3", "diff", sum_o, 64'd7);
        run_op("R3", 3'd2, 64'd10, 64'd3, 1'b1, 1'b1, 1'b0);
        run_op("R7", 3'd2, 64'd1, MOST_NEG, 1'b0, 1'b0, 1'b1);
    endtask

    // Negate: most negative value overflows, b is ignored.
    task automatic t_neg;
        run_op("R4", 3'd3, MOST_NEG, 64'h1234, 1'b0, 1'b0, 1'b1);
        chk("R4", "min ovf", W'(ovf_o), W'(1'b1));
        chk("R4", "min result", sum_o, MOST_NEG);
        run_op("R4", 3'd3, 64'd0, ONES, 1'b0, 1'b0, 1'b1);
        chk("R4", "zero", sum_o, '0);
        run_op("R4", 3'd3, 64'd1, 64'd99, 1'b0, 1'b0, 1'b1);
        chk("R4", "minus one", sum_o, ONES);
    endtask

    // Extended add with the stored carry chained in.
    task automatic t_adde;
        run_op("R5", 3'd4, ONES, 64'd0, 1'b1, 1'b0, 1'b0);
        chk("R5", "wrap carry", W'(carry_o), W'(1'b1));
        run_op("R5", 3'd4, ONES, 64'd0, 1'b0, 1'b1, 1'b1);
        chk("R5", "no carry", W'(carry_o), W'(1'b0));
    endtask

    // Extended add through the overflow flag.
    task automatic t_addex;
        run_op("R6", 3'd5, ONES, 64'd0, 1'b0, 1'b1, 1'b0);
        chk("R6", "ovf as carry", W'({ovf_o, ovf32_o}), W'(2'b11));
        run_op("R6", 3'd5, ONES, 64'd0, 1'b1, 1'b0, 1'b0);
        chk("R6", "no chain", W'({ovf_o, carry_we_o, ovf_we_o}), W'(3'b001));
        run_op("R6", 3'd5, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 1'b0, 1'b0, 1'b1);
    endtask

    // Reserved codes request no flag update.
    task automatic t_reserved;
        run_op("R11", 3'd6, ONES, 64'd1, 1'b1, 1'b1, 1'b1);
        run_op("R11", 3'd7, MOST_NEG, MOST_NEG, 1'b1, 1'b1, 1'b1);
        chk("R11", "strobes", W'({carry_we_o, ovf_we_o}), '0);
    endtask

    // Pseudo-random sweep over all mode codes and flag inputs.
    task automatic t_sweep;
        logic [63:0] s = 64'h9E37_79B9_7F4A_7C15;
        logic [63:0] ra, rb;
        for (int i = 0; i < 400; i++) begin
            s ^= s << 13; s ^= s >> 7; s ^= s << 17; ra = s;
            s ^= s << 13; s ^= s >> 7; s ^= s << 17; rb = s;
            if (i % 4 == 1) rb = ~ra;
            run_op("R9 sweep", s[2:0], ra, rb, s[5], s[6], s[7]);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_reset();
        t_add();
        t_add_carry();
        t_subf();
        t_neg();
        t_adde();
        t_addex();
        t_reserved();
        t_sweep();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule